// File: doc/BRIEF.md
# Serial ADC Capture Sequencer

This block runs one complete acquisition from a serial-output analog-to-digital converter each time the host side sends a trigger. It pulls the converter's active-low chip select, waits for the converter to signal end of conversion by raising its data line, and then produces a burst of serial clocks. The returned bits are collected into a parallel word. When the burst finishes, chip select is released and a one-cycle write strobe pushes the word into a host-side FIFO.

The clock burst starts on the converter's own end-of-conversion edge. A fixed pulse count then closes the frame, so the converter needs no handshake beyond that edge. A build-time parameter picks the capture width. In the narrow build the frame has 9 serial clocks and keeps the upper 8 result bits. In the wide build the frame has 13 clocks and keeps all 12 bits. The serial clock is the system clock divided by 2·DIV.

The output side is a plain strobe with no ready input. The FIFO must accept a word in the cycle `wr_o` is high, and there is no back-pressure. Frames are at least 2·DIV·(W+1) system cycles apart, which sets the rate a consumer has to sustain. The trigger and the serial data input each pass through a SYNC-stage synchronizer before their edges are detected. DIV must be at least SYNC+1, so that a bit presented on a falling serial-clock edge has crossed the synchronizer by the next rising edge.

Top module: `adc_capture_seq`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o`, `busy_o` and `wr_o` are 0, and `data_o` is all zeros.
- R2: A 0-to-1 edge on `trig_i` while idle drives `cs_n_o` low and `busy_o` high SYNC+1 system cycles after it is sampled, and clears the internal capture register.
- R3: A trigger edge, or a trigger held high, while `busy_o` is 1 starts no new frame, and each frame produces exactly one write strobe.
- R4: `sclk_o` stays low while idle and while waiting for end of conversion. Clocking starts only after a 0-to-1 edge on `sdata_i` seen while `cs_n_o` is low.
- R5: During the burst, `sclk_o` stays high for DIV system cycles and low for DIV system cycles.
- R6: The narrow build (WIDE=0) gives exactly 9 rising `sclk_o` edges per frame. Each rising edge shifts the synchronized `sdata_i` in at the LSB. `data_o` holds the last 8 bits, with the first bit received in bit 7, which are the upper 8 bits of the result.
- R7: On the falling edge that ends the last pulse, `cs_n_o` returns high, and `wr_o` is 1 for exactly that one system cycle, together with the new word on `data_o`.
- R8: `data_o` changes only in the cycle `wr_o` rises, and it holds its value until the next write.
- R9: The wide build (WIDE=1) gives exactly 13 rising `sclk_o` edges per frame, and `data_o` is the full 12-bit result, with the first result bit in bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Acquisition trigger from the host side (asynchronous, edge sensitive) |
| sdata_i | input | 1 | Converter serial data and end-of-conversion line (asynchronous) |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Gated serial clock, idle low |
| busy_o | output | 1 | High from the accepted trigger until the write cycle ends |
| data_o | output | W (8 or 12) | Captured word, held between writes |
| wr_o | output | 1 | One-cycle write strobe to the host FIFO |

## Verification
A narrow and a wide instance run side by side on a shared trigger. Each sees its own converter model, which shifts out bits of one 12-bit word on falling clock edges. The words cover all-zeros, all-ones, alternating bits and single end bits. All-zeros and all-ones expose bits dropped or taken from the end-of-conversion level. Alternating patterns expose a shift that is off by one position. Words that differ only in bits 3..0 separate the two widths. The conversion delay ranges from one cycle to tens of cycles, so the wait for the data-line edge is tested apart from the trigger path. Triggers are also repeated during the wait and during the burst, and one trigger is held high for many cycles, to show that frames never overlap.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_EOC,
    ST_CLOCKING,
    ST_WRITE
  } seq_state_e;

  // Kept result bits for the selected build
  function automatic int res_width(bit wide);
    return wide ? 12 : 8;
  endfunction

  // Serial clocks per frame: one leading pulse plus one per kept bit
  function automatic int frame_clocks(bit wide);
    return res_width(wide) + 1;
  endfunction

endpackage

// File: rtl/adc_seq_sync.sv
// Multi-stage synchronizer that also returns the stage after the output,
// so the caller can detect edges on the synchronized level.
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign level_o = chain[STAGES-1];
  assign prev_o  = chain[STAGES];
endmodule

// File: rtl/adc_seq_sclk.sv
// Divided serial clock with pulse counter; idle low whenever en is low.
module adc_seq_sclk #(
  parameter int DIV  = 4,
  parameter int NCLK = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk_o,
  output logic rise_o,
  output logic last_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PW = $clog2(NCLK + 1);

  logic [CW-1:0] div_cnt;
  logic [PW-1:0] pulses;
  logic          tick;

  assign tick   = en && (div_cnt == CW'(DIV - 1));
  assign rise_o = tick && !sclk_o;
  assign last_o = tick && sclk_o && (pulses == PW'(NCLK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_o  <= 1'b0;
      pulses  <= '0;
    end else if (!en) begin
      div_cnt <= '0;
      sclk_o  <= 1'b0;
      pulses  <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk_o  <= !sclk_o;
      if (!sclk_o) pulses <= pulses + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_shift.sv
// Serial-to-parallel register, MSB first, clearable.
module adc_seq_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr)   q_o <= '0;
    else if (shift) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int DIV  = 4,
  parameter int SYNC = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         trig_i,
  input  logic                         sdata_i,
  output logic                         cs_n_o,
  output logic                         sclk_o,
  output logic                         busy_o,
  output logic [res_width(WIDE)-1:0]   data_o,
  output logic                         wr_o
);
  localparam int W    = res_width(WIDE);
  localparam int NCLK = frame_clocks(WIDE);

  // index 0: trigger, index 1: serial data
  logic [1:0] raw, lvl, prv, rise;
  assign raw = {sdata_i, trig_i};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    adc_seq_sync #(.STAGES(SYNC)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (raw[i]),
      .level_o (lvl[i]),
      .prev_o  (prv[i])
    );
    assign rise[i] = lvl[i] && !prv[i];
  end

  seq_state_e   state;
  logic         clk_en, bit_rise, frame_end, clr_sr;
  logic [W-1:0] sr_q;

  assign clk_en = (state == ST_CLOCKING);
  assign clr_sr = (state == ST_IDLE) && rise[0];

  adc_seq_sclk #(.DIV(DIV), .NCLK(NCLK)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (clk_en),
    .sclk_o (sclk_o),
    .rise_o (bit_rise),
    .last_o (frame_end)
  );

  adc_seq_shift #(.W(W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_sr),
    .shift (bit_rise),
    .bit_i (lvl[1]),
    .q_o   (sr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cs_n_o <= 1'b1;
      wr_o   <= 1'b0;
      data_o <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rise[0]) begin
          cs_n_o <= 1'b0;
          state  <= ST_WAIT_EOC;
        end
        ST_WAIT_EOC: if (rise[1]) state <= ST_CLOCKING;
        ST_CLOCKING: if (frame_end) begin
          cs_n_o <= 1'b1;
          wr_o   <= 1'b1;
          data_o <= sr_q;
          state  <= ST_WRITE;
        end
        default: begin
          wr_o  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/adc_capture_seq_chk.sv
module adc_capture_seq_chk
  import adc_seq_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n_o,
  input logic                       sclk_o,
  input logic                       busy_o,
  input logic                       wr_o,
  input logic [res_width(WIDE)-1:0] data_o
);
  localparam int NCLK = frame_clocks(WIDE);

  logic       sclk_q;
  logic [4:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      pcnt   <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o) pcnt <= '0;
      else if (sclk_o && !sclk_q) pcnt <= pcnt + 1'b1;
    end
  end

  AST_BUSY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o); // R2
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o); // R4
  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o); // R4
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= 5'(NCLK)); // R6
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (pcnt == 5'(NCLK))); // R6
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o); // R7
  AST_WR_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (cs_n_o && !$past(cs_n_o))); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_o |-> $stable(data_o)); // R8
endmodule

bind adc_capture_seq adc_capture_seq_chk #(.WIDE(WIDE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n_o (cs_n_o),
  .sclk_o (sclk_o),
  .busy_o (busy_o),
  .wr_o   (wr_o),
  .data_o (data_o)
);

// File: tb/adc_bench_models.sv
// Behavioural reference of the sequencer, one step per system clock.
module adc_ref_model #(
  parameter bit WIDE = 1'b0,
  parameter int DIV  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig,
  input  logic        sdata,
  output logic        cs_n,
  output logic        sclk,
  output logic        busy,
  output logic        wr,
  output logic [11:0] data
);
  int nbits, pulses_needed, mode, ticks, pulses, acc;
  int th [3];
  int sh [3];
  bit t_edge, s_edge;
  int s_lvl;

  initial begin
    nbits = WIDE ? 12 : 8;
    pulses_needed = nbits + 1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; ticks = 0; pulses = 0; acc = 0;
      for (int i = 0; i < 3; i++) begin th[i] = 0; sh[i] = 0; end
      cs_n = 1; sclk = 0; wr = 0; data = 0; busy = 0;
    end else begin
      // the synchronized view lags the pin by two samples
      t_edge = (th[1] == 1) && (th[2] == 0);
      s_edge = (sh[1] == 1) && (sh[2] == 0);
      s_lvl  = sh[1];
      th[2] = th[1]; th[1] = th[0]; th[0] = int'(trig);
      sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = int'(sdata);
      case (mode)
        0: if (t_edge) begin cs_n = 0; acc = 0; mode = 1; end
        1: if (s_edge) begin mode = 2; ticks = 0; pulses = 0; end
        2: begin
          if (ticks == DIV - 1) begin
            ticks = 0;
            if (sclk == 0) begin
              sclk = 1;
              pulses++;
              acc = ((acc << 1) | s_lvl) & ((1 << nbits) - 1);
            end else begin
              sclk = 0;
              if (pulses == pulses_needed) begin
                cs_n = 1; wr = 1; data = 12'(acc); mode = 3;
              end
            end
          end else ticks++;
        end
        default: begin wr = 0; mode = 0; end
      endcase
      busy = (mode != 0);
    end
  end
endmodule

// Converter stand-in: raises the data line conv_wait cycles after select,
// then presents word bits MSB first, one per falling serial-clock edge.
module adc_stub (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic [11:0] word,
  input  int          conv_wait,
  output logic        sdata,
  output int          rises
);
  int  wait_cnt, falls;
  bit  eoc_done;
  logic sclk_q = 1'b0;
  logic cs_q   = 1'b1;

  initial begin sdata = 0; rises = 0; wait_cnt = 0; falls = 0; eoc_done = 0; end

  always @(negedge clk) begin
    if (cs_q && !cs_n) rises = 0;
    if (!cs_n && sclk && !sclk_q) rises++;
    if (cs_n) begin
      sdata = 0; wait_cnt = 0; falls = 0; eoc_done = 0;
    end else if (!eoc_done) begin
      wait_cnt++;
      if (wait_cnt >= conv_wait) begin sdata = 1; eoc_done = 1; end
    end else if (sclk_q && !sclk) begin
      falls++;
      sdata = (12 - falls >= 0) ? word[12 - falls] : 1'b0;
    end
    sclk_q = sclk;
    cs_q   = cs_n;
  end
endmodule

// File: tb/tb_adc_capture_seq.sv
module tb_adc_capture_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [11:0] word = '0;
  int conv_wait = 5;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;
  bit cmp_on = 0;
  int wr8_cnt = 0, wr12_cnt = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  // narrow build
  logic cs8, sclk8, busy8, wr8, sd8;
  logic [7:0] data8;
  int rises8;
  // wide build
  logic cs12, sclk12, busy12, wr12, sd12;
  logic [11:0] data12;
  int rises12;

  adc_capture_seq #(.WIDE(1'b0), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sdata_i(sd8),
    .cs_n_o(cs8), .sclk_o(sclk8), .busy_o(busy8), .data_o(data8), .wr_o(wr8));
  adc_capture_seq #(.WIDE(1'b1), .DIV(DIV)) dut12 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .sdata_i(sd12),
    .cs_n_o(cs12), .sclk_o(sclk12), .busy_o(busy12), .data_o(data12), .wr_o(wr12));

  adc_stub adc8  (.clk(clk), .cs_n(cs8),  .sclk(sclk8),  .word(word), .conv_wait(conv_wait), .sdata(sd8),  .rises(rises8));
  adc_stub adc12 (.clk(clk), .cs_n(cs12), .sclk(sclk12), .word(word), .conv_wait(conv_wait), .sdata(sd12), .rises(rises12));

  logic m8_cs, m8_sclk, m8_busy, m8_wr, m12_cs, m12_sclk, m12_busy, m12_wr;
  logic [11:0] m8_data, m12_data;

  adc_ref_model #(.WIDE(1'b0), .DIV(DIV)) mdl8 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sdata(sd8),
    .cs_n(m8_cs), .sclk(m8_sclk), .busy(m8_busy), .wr(m8_wr), .data(m8_data));
  adc_ref_model #(.WIDE(1'b1), .DIV(DIV)) mdl12 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .sdata(sd12),
    .cs_n(m12_cs), .sclk(m12_sclk), .busy(m12_busy), .wr(m12_wr), .data(m12_data));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R2", "cs_n narrow", 32'(cs8), 32'(m8_cs));
      chk("R5", "sclk narrow", 32'(sclk8), 32'(m8_sclk));
      chk("R3", "busy narrow", 32'(busy8), 32'(m8_busy));
      chk("R7", "wr narrow", 32'(wr8), 32'(m8_wr));
      chk("R8", "data narrow", 32'(data8), 32'(m8_data[7:0]));
      chk("R2", "cs_n wide", 32'(cs12), 32'(m12_cs));
      chk("R5", "sclk wide", 32'(sclk12), 32'(m12_sclk));
      chk("R3", "busy wide", 32'(busy12), 32'(m12_busy));
      chk("R7", "wr wide", 32'(wr12), 32'(m12_wr));
      chk("R8", "data wide", 32'(data12), 32'(m12_data));
    end
  end

  // frame-level checks at each write strobe
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      if (wr8) begin
        wr8_cnt++;
        chk("R6", "narrow word", 32'(data8), 32'(word[11:4]));
        chk("R6", "narrow pulse count", 32'(rises8), 32'd9);
      end
      if (wr12) begin
        wr12_cnt++;
        chk("R9", "wide word", 32'(data12), 32'(word));
        chk("R9", "wide pulse count", 32'(rises12), 32'd13);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    cycles(1);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    cycles(4);
    while ((busy8 || busy12) && guard < 3000) begin
      cycles(1);
      guard++;
    end
    cycles(6);
  endtask

  // mode 0: single trigger, 1: retrigger in burst, 2: retrigger while waiting, 3: held trigger
  task automatic run_frame(input logic [11:0] w, input int cw, input int mode);
    int c8 = wr8_cnt;
    int c12 = wr12_cnt;
    word = w;
    conv_wait = cw;
    if (mode == 3) begin
      trig = 1'b1;
      cycles(60);
      trig = 1'b0;
    end else begin
      pulse_trig();
      if (mode == 2) begin
        cycles(cw / 2);
        chk("R4", "sclk before EOC", 32'(sclk8 | sclk12), 32'd0);
        chk("R2", "cs_n low during wait", 32'(cs8 | cs12), 32'd0);
        pulse_trig();
      end else if (mode == 1) begin
        cycles(cw + 20);
        pulse_trig();
      end
    end
    wait_idle();
    chk("R3", "narrow writes per frame", 32'(wr8_cnt - c8), 32'd1);
    chk("R3", "wide writes per frame", 32'(wr12_cnt - c12), 32'd1);
    chk("R4", "idle clock low", 32'(sclk8 | sclk12), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk("R1", "cs_n reset", 32'(cs8 & cs12), 32'd1);
    chk("R1", "sclk reset", 32'(sclk8 | sclk12), 32'd0);
    chk("R1", "busy reset", 32'(busy8 | busy12), 32'd0);
    chk("R1", "wr reset", 32'(wr8 | wr12), 32'd0);
    chk("R1", "data reset", 32'(data8) | 32'(data12), 32'd0);
    cmp_on = 1;

    // R2 latency: trigger edge seen after synchronizer, cs low one cycle later
    word = 12'hA5C;
    conv_wait = 10;
    trig = 1'b1;
    cycles(2);
    chk("R2", "cs_n not yet low", 32'(cs8), 32'd1);
    cycles(1);
    chk("R2", "cs_n low after sync", 32'(cs8), 32'd0);
    chk("R2", "busy after sync", 32'(busy8), 32'd1);
    trig = 1'b0;
    wait_idle();

    run_frame(12'h000, 3, 1);
    run_frame(12'hFFF, 25, 2);
    run_frame(12'h5A3, 6, 3);
    run_frame(12'h801, 1, 0);
    run_frame(12'h80E, 15, 0);
    run_frame(12'h3C7, 40, 2);
    run_frame(12'h555, 8, 1);

    // R8: data held after the last frame
    chk("R8", "narrow data held", 32'(data8), 32'h55);
    chk("R8", "wide data held", 32'(data12), 32'h555);
    finish_run();
  end
endmodule